// File: doc/BRIEF.md
# Dataflow Memory Ordering Gate

This block sits next to a single memory operation (a load or a store) in a spatial dataflow accelerator and decides the cycle in which that operation may go to the cache. Up to a fixed number of older memory operations feed it ordering edges. Each edge is set up as unused, as a hard dependency, or as a speculative dependency. A hard dependency behaves like an ordinary data token: the gate waits for the older operation's completion strobe. A speculative dependency also carries the older operation's address. The gate compares that address with its own, and when the two differ it lets the operation go without waiting for the older one.

All checks are pairwise and sit at the younger operation. Each edge that can be speculative has exactly one comparator, and every edge is evaluated independently and in parallel with the others. No central associative search is involved. Two loads never need ordering, so an edge between two loads imposes nothing, whatever its configuration. The gate fires once per dataflow firing. A per-iteration clear pulse drops every collected token and latched address and re-arms the gate for the next firing.

Top module: `mem_order_gate`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `issue` is 0.
- R2: `issue` is asserted only after the local address has been seen valid since the last clear. It is a one-cycle pulse that goes high in the cycle after the clock edge at which the last missing condition was sampled.
- R3: Edge i is configured by `edge_cfg[2i+1:2i]`. The codes are 2'b00 unused (no constraint), 2'b01 hard dependency, 2'b10 speculative dependency, and 2'b11, which is handled as a hard dependency.
- R4: A hard-dependency edge blocks issue until its `edge_done` strobe has been seen since the last clear.
- R5: A speculative edge is satisfied without completion once the older address it received differs from the local address.
- R6: A speculative edge whose older address equals the local address blocks issue until its `edge_done` strobe is seen.
- R7: A speculative edge whose older address has not yet arrived blocks issue. A completion strobe that arrives before any address satisfies the edge.
- R8: An edge joining two loads imposes no constraint, whatever its configuration. Such an edge is one where `local_is_store`=0 and `older_is_store[i]`=0.
- R9: At most one issue pulse occurs between clears. When `iter_clr` is high at an edge, all tokens, latched addresses and the fired state are cleared, no issue follows that edge, and strobes presented in that cycle are discarded.
- R10: An edge whose bit in parameter `CMP_MASK` is 0 has no comparator. A speculative configuration on that edge acts as a hard dependency.
- R11: Both the local address and an older address are latched at their first valid strobe. An older address that arrives before the local one is compared once the local address arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iter_clr | input | 1 | Per-iteration clear pulse, re-arms the gate |
| edge_cfg | input | 2*NUM_EDGES | Per-edge dependency code (R3) |
| local_is_store | input | 1 | 1 when the local operation is a store |
| older_is_store | input | NUM_EDGES | Per edge, 1 when the older operation is a store |
| local_addr_vld | input | 1 | Local address valid strobe |
| local_addr | input | ADDR_W | Local operation address |
| edge_addr_vld | input | NUM_EDGES | Older address valid strobe per edge |
| edge_addr | input | NUM_EDGES*ADDR_W | Older addresses, edge i at bits [i*ADDR_W +: ADDR_W] |
| edge_done | input | NUM_EDGES | Older operation completion strobe per edge |
| issue | output | 1 | One-cycle pulse: the local operation may go to the cache |

## Verification
Every result is due exactly one clock after the edge at which its last enabling strobe was sampled. Strobes are both counted and compared in the same cycle they arrive, so a decision never waits an extra cycle. The bench drives inputs just after a falling edge and lets one rising edge pass. It then samples `issue` at the next falling edge against a reference model, which advances its own token state at that same rising edge. Directed sequences pin the cycle boundaries: the first cycle after a clear stays quiet, and the pulse lasts a single cycle and does not repeat.

// File: rtl/mem_order_pkg.sv
// Package: shared types for the dataflow memory ordering gate.
// Assumes: each edge carries a 2-bit configuration code.
package mem_order_pkg;

    // Per-edge dependency code; the encoding is visible at the top ports.
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_HARD = 2'b01,
        EDGE_SPEC = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_cfg_e;

endpackage

// File: rtl/ord_addr_hold.sv
// Module: ord_addr_hold
// Latches an address at its first valid strobe after a clear. It presents
// the address as known in the strobe cycle itself, so a comparison can use
// it with no extra cycle of latency.
// Assumes: later strobes before the next clear carry no new information.
module ord_addr_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         vld,
    input  logic [W-1:0] din,
    output logic         known,
    output logic [W-1:0] value
);
    logic         held_q;
    logic [W-1:0] addr_q;

    // Capture the first valid address; drop it on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            addr_q <= '0;
        end else if (clr) begin
            held_q <= 1'b0;
            addr_q <= '0;
        end else if (vld && !held_q) begin
            held_q <= 1'b1;
            addr_q <= din;
        end
    end

    // Present the held address, or the one arriving this cycle.
    always_comb begin
        known = held_q | vld;
        value = held_q ? addr_q : din;
    end
endmodule

// File: rtl/ord_edge_track.sv
// Module: ord_edge_track
// Tracks one incoming ordering edge. It keeps a completion token and, when
// HAS_CMP is set, holds the older address and compares it with the local
// address. Its output says whether this edge currently allows issue.
// Assumes: cfg and the load/store kinds are stable between clears.
module ord_edge_track
    import mem_order_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit HAS_CMP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  edge_cfg_e         cfg,
    input  logic              local_store,
    input  logic              older_store,
    input  logic              loc_known,
    input  logic [ADDR_W-1:0] loc_value,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic              done,
    output logic              edge_ok
);
    logic              done_q;
    logic              done_now;
    logic              old_known;
    logic [ADDR_W-1:0] old_value;
    logic              addr_differs;
    logic              ld_ld;

    // Remember the older operation's completion until the next clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       done_q <= 1'b0;
        else if (clr)     done_q <= 1'b0;
        else if (done)    done_q <= 1'b1;
    end

    assign done_now = done_q | done;
    assign ld_ld    = !local_store && !older_store;

    generate
        if (HAS_CMP) begin : g_cmp
            ord_addr_hold #(.W(ADDR_W)) u_old_addr (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .vld   (addr_vld),
                .din   (addr),
                .known (old_known),
                .value (old_value)
            );
            // Pairwise check: both addresses known and unequal.
            always_comb addr_differs = old_known && loc_known && (old_value != loc_value);
        end else begin : g_nocmp
            // No comparator: a speculative edge degrades to a hard one.
            always_comb begin
                old_known    = 1'b0;
                old_value    = '0;
                addr_differs = 1'b0;
            end
        end
    endgenerate

    // Decide whether this edge lets the local operation go.
    always_comb begin
        edge_ok = 1'b0;
        if (ld_ld) begin
            edge_ok = 1'b1;
        end else begin
            case (cfg)
                EDGE_OFF:  edge_ok = 1'b1;
                EDGE_HARD: edge_ok = done_now;
                EDGE_SPEC: edge_ok = done_now | addr_differs;
                default:   edge_ok = done_now;
            endcase
        end
    end
endmodule

// File: rtl/ord_issue_ctl.sv
// Module: ord_issue_ctl
// Combines the per-edge verdicts with the local address state. It produces
// a registered one-cycle issue pulse and then stays quiet until a clear.
// Assumes: edge_ok already includes strobes arriving this cycle.
module ord_issue_ctl #(
    parameter int NUM_EDGES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 loc_known,
    input  logic [NUM_EDGES-1:0] edge_ok,
    output logic                 issue
);
    logic fired_q;
    logic go;

    // The gate may fire now: armed, address known, every edge satisfied.
    always_comb go = !clr && !fired_q && loc_known && (&edge_ok);

    // Register the pulse and remember that this iteration has fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue   <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            issue   <= go;
            fired_q <= clr ? 1'b0 : (fired_q | go);
        end
    end
endmodule

// File: rtl/mem_order_gate.sv
// Module: mem_order_gate (top)
// Issue gate for one memory operation in a dataflow fabric. It has one
// tracker per incoming ordering edge, a comparator only on edges selected
// by CMP_MASK, and a single issue controller.
// Assumes: configuration and kinds change only together with iter_clr.
module mem_order_gate
    import mem_order_pkg::*;
#(
    parameter int                  NUM_EDGES = 4,
    parameter int                  ADDR_W    = 32,
    parameter logic [NUM_EDGES-1:0] CMP_MASK = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          iter_clr,
    input  logic [2*NUM_EDGES-1:0]        edge_cfg,
    input  logic                          local_is_store,
    input  logic [NUM_EDGES-1:0]          older_is_store,
    input  logic                          local_addr_vld,
    input  logic [ADDR_W-1:0]             local_addr,
    input  logic [NUM_EDGES-1:0]          edge_addr_vld,
    input  logic [NUM_EDGES*ADDR_W-1:0]   edge_addr,
    input  logic [NUM_EDGES-1:0]          edge_done,
    output logic                          issue
);
    localparam int CFG_W = 2;

    logic              loc_known;
    logic [ADDR_W-1:0] loc_value;
    logic [NUM_EDGES-1:0] edge_ok;

    ord_addr_hold #(.W(ADDR_W)) u_local_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (iter_clr),
        .vld   (local_addr_vld),
        .din   (local_addr),
        .known (loc_known),
        .value (loc_value)
    );

    generate
        for (genvar i = 0; i < NUM_EDGES; i++) begin : g_edge
            ord_edge_track #(
                .ADDR_W  (ADDR_W),
                .HAS_CMP (CMP_MASK[i])
            ) u_track (
                .clk         (clk),
                .rst_n       (rst_n),
                .clr         (iter_clr),
                .cfg         (edge_cfg_e'(edge_cfg[CFG_W*i +: CFG_W])),
                .local_store (local_is_store),
                .older_store (older_is_store[i]),
                .loc_known   (loc_known),
                .loc_value   (loc_value),
                .addr_vld    (edge_addr_vld[i]),
                .addr        (edge_addr[ADDR_W*i +: ADDR_W]),
                .done        (edge_done[i]),
                .edge_ok     (edge_ok[i])
            );
        end
    endgenerate

    ord_issue_ctl #(.NUM_EDGES(NUM_EDGES)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (iter_clr),
        .loc_known (loc_known),
        .edge_ok   (edge_ok),
        .issue     (issue)
    );
endmodule

// File: rtl/mem_order_gate_chk.sv
// Module: mem_order_gate_chk
// Protocol checker bound to mem_order_gate. It keeps its own shadow of the
// strobes seen since the last clear and checks the issue pulse against it.
// Assumes: configuration is stable between clears.
module mem_order_gate_chk #(
    parameter int NUM_EDGES = 4,
    parameter int ADDR_W    = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   iter_clr,
    input logic [2*NUM_EDGES-1:0] edge_cfg,
    input logic                   local_is_store,
    input logic [NUM_EDGES-1:0]   older_is_store,
    input logic                   local_addr_vld,
    input logic [NUM_EDGES-1:0]   edge_done,
    input logic                   issue
);
    logic [NUM_EDGES-1:0]   seen_done_q;
    logic                   seen_loc_q;
    logic                   fired_s_q;
    logic [2*NUM_EDGES-1:0] cfg_q;
    logic                   lst_q;
    logic [NUM_EDGES-1:0]   ost_q;

    // Shadow bookkeeping of strobes and pulses since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_done_q <= '0;
            seen_loc_q  <= 1'b0;
            fired_s_q   <= 1'b0;
            cfg_q       <= '0;
            lst_q       <= 1'b0;
            ost_q       <= '0;
        end else begin
            cfg_q <= edge_cfg;
            lst_q <= local_is_store;
            ost_q <= older_is_store;
            if (iter_clr) begin
                seen_done_q <= '0;
                seen_loc_q  <= 1'b0;
                fired_s_q   <= 1'b0;
            end else begin
                seen_done_q <= seen_done_q | edge_done;
                seen_loc_q  <= seen_loc_q | local_addr_vld;
                fired_s_q   <= fired_s_q | issue;
            end
        end
    end

    AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !fired_s_q);                                  // R9
    AST_LOCAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> seen_loc_q);                                  // R2
    AST_QUIET_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        iter_clr |=> !issue);                                   // R9

    generate
        for (genvar i = 0; i < NUM_EDGES; i++) begin : g_hard
            AST_HARD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
                (issue && cfg_q[2*i] && (lst_q || ost_q[i])) |-> seen_done_q[i]);  // R4
        end
    endgenerate
endmodule

bind mem_order_gate mem_order_gate_chk #(
    .NUM_EDGES (NUM_EDGES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .iter_clr       (iter_clr),
    .edge_cfg       (edge_cfg),
    .local_is_store (local_is_store),
    .older_is_store (older_is_store),
    .local_addr_vld (local_addr_vld),
    .edge_done      (edge_done),
    .issue          (issue)
);

// File: tb/mem_order_gate_test.sv
// Bench for mem_order_gate: directed corner cases, then seeded random
// iterations, all checked against a reference model of the requirements.
module mem_order_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam int AW = 32;
    localparam logic [NE-1:0] CMP = 4'b0111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iter_clr = 1'b0;
    logic [2*NE-1:0] edge_cfg = '0;
    logic          local_is_store = 1'b0;
    logic [NE-1:0] older_is_store = '0;
    logic          local_addr_vld = 1'b0;
    logic [AW-1:0] local_addr = '0;
    logic [NE-1:0] edge_addr_vld = '0;
    logic [NE*AW-1:0] edge_addr = '0;
    logic [NE-1:0] edge_done = '0;
    logic          issue;

    int n_checks = 0;
    int n_fail = 0;

    // Reference model state
    logic [NE-1:0] m_done = '0;
    logic [NE-1:0] m_aseen = '0;
    logic [AW-1:0] m_aval [NE];
    logic          m_lseen = 1'b0;
    logic [AW-1:0] m_lval = '0;
    logic          m_fired = 1'b0;

    mem_order_gate #(.NUM_EDGES(NE), .ADDR_W(AW), .CMP_MASK(CMP)) uut (
        .clk(clk), .rst_n(rst_n), .iter_clr(iter_clr), .edge_cfg(edge_cfg),
        .local_is_store(local_is_store), .older_is_store(older_is_store),
        .local_addr_vld(local_addr_vld), .local_addr(local_addr),
        .edge_addr_vld(edge_addr_vld), .edge_addr(edge_addr),
        .edge_done(edge_done), .issue(issue)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: issue=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected issue decision for the inputs now applied (R2..R11).
    function automatic logic model_go();
        logic lk;
        logic [AW-1:0] lv;
        logic all_ok;
        lk = m_lseen | local_addr_vld;
        lv = m_lseen ? m_lval : local_addr;
        all_ok = 1'b1;
        for (int i = 0; i < NE; i++) begin
            logic [1:0] c;
            logic ok;
            logic ak;
            logic [AW-1:0] av;
            c = edge_cfg[2*i +: 2];
            ok = 1'b0;
            if (c == 2'b00 || (!local_is_store && !older_is_store[i])) ok = 1'b1;
            else if (m_done[i] || edge_done[i]) ok = 1'b1;
            else if (c == 2'b10 && CMP[i]) begin
                ak = m_aseen[i] | edge_addr_vld[i];
                av = m_aseen[i] ? m_aval[i] : edge_addr[i*AW +: AW];
                if (ak && lk && av != lv) ok = 1'b1;
            end
            all_ok &= ok;
        end
        return !iter_clr && !m_fired && lk && all_ok;
    endfunction

    // One clock: predict, advance model at the edge, check at the falling edge.
    task automatic tick(input string req);
        logic exp;
        exp = model_go();
        @(posedge clk);
        if (iter_clr) begin
            m_done = '0; m_aseen = '0; m_lseen = 1'b0; m_fired = 1'b0;
        end else begin
            m_done |= edge_done;
            for (int i = 0; i < NE; i++)
                if (edge_addr_vld[i] && !m_aseen[i]) begin
                    m_aseen[i] = 1'b1;
                    m_aval[i] = edge_addr[i*AW +: AW];
                end
            if (local_addr_vld && !m_lseen) begin
                m_lseen = 1'b1;
                m_lval = local_addr;
            end
            if (exp) m_fired = 1'b1;
        end
        @(negedge clk);
        chk(req, issue, exp);
        iter_clr = 1'b0; local_addr_vld = 1'b0; edge_addr_vld = '0; edge_done = '0;
    endtask

    task automatic new_iter(input logic [2*NE-1:0] cfg, input logic lst, input logic [NE-1:0] ost);
        iter_clr = 1'b1; edge_cfg = cfg; local_is_store = lst; older_is_store = ost;
        tick("R9 clear");
        chk("R9", issue, 1'b0);
    endtask

    task automatic set_eaddr(input int i, input logic [AW-1:0] a);
        edge_addr[i*AW +: AW] = a; edge_addr_vld[i] = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < NE; i++) m_aval[i] = '0;
        @(negedge clk);
        chk("R1 in reset", issue, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tick("R1");
        chk("R1 after reset", issue, 1'b0);

        // R4: hard edge waits for completion
        new_iter(8'b00_00_00_01, 1'b1, 4'b1111);
        local_addr = 32'h40; local_addr_vld = 1'b1; tick("R4");
        chk("R4 no done", issue, 1'b0);
        edge_done[0] = 1'b1; tick("R4");
        chk("R4 done", issue, 1'b1);
        tick("R9"); chk("R9 single pulse", issue, 1'b0);

        // R5: speculative mismatch
        new_iter(8'b00_00_10_00, 1'b1, 4'b1111);
        local_addr = 32'h40; local_addr_vld = 1'b1; set_eaddr(1, 32'h80); tick("R5");
        chk("R5 mismatch", issue, 1'b1);

        // R6: speculative match waits for completion
        new_iter(8'b00_00_10_00, 1'b0, 4'b1111);
        local_addr = 32'h40; local_addr_vld = 1'b1; set_eaddr(1, 32'h40); tick("R6");
        chk("R6 match", issue, 1'b0);
        tick("R6"); chk("R6 still", issue, 1'b0);
        edge_done[1] = 1'b1; tick("R6");
        chk("R6 done", issue, 1'b1);

        // R7: address absent blocks; completion first satisfies
        new_iter(8'b00_10_00_00, 1'b1, 4'b1111);
        local_addr = 32'h44; local_addr_vld = 1'b1; tick("R7");
        chk("R7 no addr", issue, 1'b0);
        edge_done[2] = 1'b1; tick("R7");
        chk("R7 early done", issue, 1'b1);

        // R11: older address first, local later
        new_iter(8'b00_00_00_10, 1'b1, 4'b1111);
        set_eaddr(0, 32'h10); tick("R11");
        chk("R11 no local", issue, 1'b0);
        local_addr = 32'h20; local_addr_vld = 1'b1; tick("R11");
        chk("R11 late compare", issue, 1'b1);

        // R8: load-load edges ignored; a store edge still counts
        new_iter(8'b01_01_01_01, 1'b0, 4'b0000);
        local_addr = 32'h8; local_addr_vld = 1'b1; tick("R8");
        chk("R8 ld-ld", issue, 1'b1);
        new_iter(8'b01_01_01_01, 1'b0, 4'b0100);
        local_addr_vld = 1'b1; tick("R8");
        chk("R8 st-ld edge", issue, 1'b0);

        // R3: reserved code acts as hard
        new_iter(8'b00_00_00_11, 1'b1, 4'b1111);
        local_addr_vld = 1'b1; tick("R3");
        chk("R3 code 11", issue, 1'b0);
        edge_done[0] = 1'b1; tick("R3");
        chk("R3 code 11 done", issue, 1'b1);

        // R10: no comparator on edge 3
        new_iter(8'b10_00_00_00, 1'b1, 4'b1111);
        local_addr = 32'h40; local_addr_vld = 1'b1; set_eaddr(3, 32'h80); tick("R10");
        chk("R10 no cmp", issue, 1'b0);
        edge_done[3] = 1'b1; tick("R10");
        chk("R10 done", issue, 1'b1);

        // R9: strobes in a clear cycle are discarded
        new_iter(8'b00_00_00_01, 1'b1, 4'b1111);
        iter_clr = 1'b1; edge_done[0] = 1'b1; tick("R9");
        local_addr_vld = 1'b1; tick("R9");
        chk("R9 discarded", issue, 1'b0);

        // R2: no local address means no issue
        new_iter(8'b00_00_00_00, 1'b1, 4'b1111);
        tick("R2"); chk("R2 no local", issue, 1'b0);
        local_addr_vld = 1'b1; tick("R2");
        chk("R2 local", issue, 1'b1);

        // Random iterations
        void'($urandom(32'd1234));
        for (int it = 0; it < 400; it++) begin
            new_iter(8'($urandom), 1'($urandom), 4'($urandom));
            local_addr = ($urandom % 2) ? 32'h100 : 32'h104;
            for (int c = 0; c < 10; c++) begin
                local_addr_vld = ($urandom % 4) == 0;
                for (int i = 0; i < NE; i++) begin
                    edge_done[i] = ($urandom % 6) == 0;
                    if (($urandom % 4) == 0) set_eaddr(i, ($urandom % 2) ? 32'h100 : 32'h104);
                end
                tick("R4 R5 R6 R7 R8 random");
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule